// File: doc/BRIEF.md
# Registered-DIMM Self-Refresh Power Sequencer

This block sits on the controller side of a registered DDR memory module. It puts the module into a deep low-power self-refresh state and brings it back out. To do this it issues the self-refresh command, then waits one extra clock because the module's register stage delays every command by a cycle. After that it pulls the register's asynchronous reset line low. That forces all register outputs, and with them the devices' CKE, to a low level. Once a deactivation wait has passed, it releases the address and control bus to high impedance.

There are two flavours of low power, chosen at entry by a mode input. In clock-off mode the sequencer drops its clock-enable request while in low power. On wake it raises the request again, waits for the clock-stable indication, and then waits a PLL settling interval. In clock-running mode the clocks are never stopped and the settling wait is skipped. In both modes the exit proceeds the same way. Valid pre-reset levels (deselect with CKE low) are driven on the bus first. The reset line is released next. The inputs are then held unchanged for an activation wait, after which a ready flag hands the bus back for the standard self-refresh exit command sequence.

A wake request that arrives while entry is still under way is remembered and acted on once low power is reached. All three waits share one down-counter.

Top module: `srseq_top`

## Requirements
- R1: After synchronous reset the outputs are: cke=1, cs_n=1, ras_n=1, cas_n=1, we_n=1, reg_rst_n=1, bus_oe=1, clk_en=1, exit_ready=0.
- R2: An lp_req sampled high in normal operation makes the next cycle drive the self-refresh entry command for exactly one cycle: cke=0, cs_n=0, ras_n=0, cas_n=0, we_n=1, with reg_rst_n=1 and bus_oe=1.
- R3: The cycle after the entry command drives deselect with CKE low (cke=0, cs_n=ras_n=cas_n=we_n=1) while reg_rst_n is still 1. reg_rst_n falls in the following cycle.
- R4: reg_rst_n stays low with bus_oe=1 for INACT_CYC cycles, and then bus_oe drops to 0 (low power). Whenever reg_rst_n is 0, cke is 0.
- R5: In low power, clk_en is 0 if clk_off_mode was 1 when lp_req was accepted, and 1 otherwise.
- R6: In clock-off mode a wake makes clk_en 1 in the next cycle while bus_oe stays 0. The sequencer waits for clk_stable, and bus_oe returns to 1 only after a further PLL_US*CLK_MHZ cycles.
- R7: In clock-running mode a wake sampled in low power makes the next cycle drive bus_oe=1 with deselect and CKE low while reg_rst_n is still 0.
- R8: bus_oe is 1 with deselect and CKE low for exactly one cycle before reg_rst_n rises, and the command outputs do not change across the rise.
- R9: ACT_CYC cycles after reg_rst_n rises, exit_ready is 1 for one cycle, and the next cycle is normal operation with cke=1.
- R10: A wake_req pulse arriving during entry (entry command, pipeline cycle or deactivation wait) is latched, and the exit starts on the first low-power cycle.
- R11: lp_req while in low power and wake_req in normal operation are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Request to enter low power |
| wake_req | input | 1 | Request to leave low power |
| clk_off_mode | input | 1 | 1 = stop clocks in low power, sampled at entry |
| clk_stable | input | 1 | Clocks to the module are stable |
| cke | output | 1 | Clock enable to the module |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| reg_rst_n | output | 1 | Asynchronous reset of the module's register, active low |
| bus_oe | output | 1 | Output enable for address and control drivers |
| clk_en | output | 1 | Request to run the module clocks |
| exit_ready | output | 1 | One-cycle flag that the exit command sequence may start |

## Verification
The hardest situation to reach is a wake request that lands while the sequencer is still entering low power, because the wake must be held across the deactivation wait rather than acted on at once. The stimulus table includes rows that pulse wake_req during the entry-command cycle, in both clock modes. The bench then confirms that the low-power outputs appear for exactly one cycle before the exit begins. Other rows stretch the clock-stable lag and inject an lp_req inside low power, so that the waits are counted from the correct edge.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

    typedef enum logic [3:0] {
        ST_NORMAL,
        ST_SRE_CMD,
        ST_REG_PIPE,
        ST_INACT,
        ST_LOWPWR,
        ST_CLK_WAIT,
        ST_PLL_WAIT,
        ST_PRE_RST,
        ST_ACT,
        ST_READY
    } seq_state_t;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    typedef struct packed {
        logic reg_rst_n;
        logic bus_oe;
        logic clk_en;
        logic exit_ready;
    } pin_ctl_t;

    // deselect with clock enable high (normal idle)
    localparam ddr_cmd_t CMD_IDLE_HI = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    // deselect with clock enable low (held during reset phases)
    localparam ddr_cmd_t CMD_IDLE_LO = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    // self-refresh entry
    localparam ddr_cmd_t CMD_SR_ENTER = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    // A wait of n cycles loads n-1: the state is left on the cycle the counter reads zero.
    function automatic int unsigned wait_load(input int unsigned n);
        return (n == 0) ? 0 : n - 1;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic in_entry(input seq_state_t s);
        return (s == ST_SRE_CMD) || (s == ST_REG_PIPE) || (s == ST_INACT);
    endfunction

endpackage

// File: rtl/srseq_timer.sv
module srseq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // the shared counter parks at zero and never wraps (R4, R6, R9 timing)
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/srseq_ctrl.sv
module srseq_ctrl
    import srseq_pkg::*;
#(
    parameter int unsigned TW        = 8,
    parameter logic [TW-1:0] INACT_LD = '0,
    parameter logic [TW-1:0] ACT_LD   = '0,
    parameter logic [TW-1:0] PLL_LD   = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lp_req,
    input  logic          wake_req,
    input  logic          clk_off_mode,
    input  logic          clk_stable,
    input  logic          tmr_expired,
    output seq_state_t    state,
    output logic          mode_off,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val
);
    seq_state_t state_q, state_d;
    logic       mode_q;
    logic       wake_pend_q;
    logic       wake_now;

    assign wake_now = wake_req || wake_pend_q;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_NORMAL:   if (lp_req) state_d = ST_SRE_CMD;
            ST_SRE_CMD:  state_d = ST_REG_PIPE;
            ST_REG_PIPE: begin
                state_d  = ST_INACT;
                tmr_load = 1'b1;
                tmr_val  = INACT_LD;
            end
            ST_INACT:    if (tmr_expired) state_d = ST_LOWPWR;
            ST_LOWPWR: begin
                if (wake_now) state_d = mode_q ? ST_CLK_WAIT : ST_PRE_RST;
            end
            ST_CLK_WAIT: begin
                if (clk_stable) begin
                    state_d  = ST_PLL_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = PLL_LD;
                end
            end
            ST_PLL_WAIT: if (tmr_expired) state_d = ST_PRE_RST;
            ST_PRE_RST: begin
                state_d  = ST_ACT;
                tmr_load = 1'b1;
                tmr_val  = ACT_LD;
            end
            ST_ACT:      if (tmr_expired) state_d = ST_READY;
            ST_READY:    state_d = ST_NORMAL;
            default:     state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_NORMAL;
            mode_q      <= 1'b0;
            wake_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_NORMAL && lp_req) begin
                mode_q <= clk_off_mode;
            end
            if (in_entry(state_q) && wake_req) begin
                wake_pend_q <= 1'b1;
            end else if (state_q == ST_LOWPWR) begin
                wake_pend_q <= 1'b0;
            end
        end
    end

    assign state    = state_q;
    assign mode_off = mode_q;

    p_sre_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SRE_CMD) |=> (state_q == ST_REG_PIPE));
    p_pending_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOWPWR && wake_pend_q) |=> (state_q != ST_LOWPWR));
    p_lp_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOWPWR && !wake_req && !wake_pend_q) |=> (state_q == ST_LOWPWR));
    p_wake_in_normal_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL) |=> !wake_pend_q);
endmodule

// File: rtl/srseq_drive.sv
module srseq_drive
    import srseq_pkg::*;
(
    input  seq_state_t state,
    input  logic       mode_off,
    output ddr_cmd_t   cmd,
    output pin_ctl_t   pins
);
    always_comb begin
        cmd  = CMD_IDLE_LO;
        pins = '{reg_rst_n: 1'b1, bus_oe: 1'b1, clk_en: 1'b1, exit_ready: 1'b0};
        unique case (state)
            ST_NORMAL:   cmd = CMD_IDLE_HI;
            ST_SRE_CMD:  cmd = CMD_SR_ENTER;
            ST_REG_PIPE: cmd = CMD_IDLE_LO;
            ST_INACT:    pins.reg_rst_n = 1'b0;
            ST_LOWPWR: begin
                pins.reg_rst_n = 1'b0;
                pins.bus_oe    = 1'b0;
                pins.clk_en    = !mode_off;
            end
            ST_CLK_WAIT, ST_PLL_WAIT: begin
                pins.reg_rst_n = 1'b0;
                pins.bus_oe    = 1'b0;
            end
            ST_PRE_RST:  pins.reg_rst_n = 1'b0;
            ST_ACT:      cmd = CMD_IDLE_LO;
            ST_READY:    pins.exit_ready = 1'b1;
            default:     cmd = CMD_IDLE_HI;
        endcase
    end
endmodule

// File: rtl/srseq_top.sv
module srseq_top
    import srseq_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 200,
    parameter int unsigned PLL_US    = 100,
    parameter int unsigned ACT_CYC   = 8,
    parameter int unsigned INACT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_req,
    input  logic wake_req,
    input  logic clk_off_mode,
    input  logic clk_stable,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic reg_rst_n,
    output logic bus_oe,
    output logic clk_en,
    output logic exit_ready
);
    localparam int unsigned PLL_CYC = PLL_US * CLK_MHZ;
    localparam int unsigned MAX_CYC = max3(PLL_CYC, ACT_CYC, INACT_CYC);
    localparam int unsigned TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [TW-1:0] INACT_LD = TW'(wait_load(INACT_CYC));
    localparam logic [TW-1:0] ACT_LD   = TW'(wait_load(ACT_CYC));
    localparam logic [TW-1:0] PLL_LD   = TW'(wait_load(PLL_CYC));

    seq_state_t    state;
    logic          mode_off;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    ddr_cmd_t      cmd;
    pin_ctl_t      pins;

    srseq_ctrl #(
        .TW       (TW),
        .INACT_LD (INACT_LD),
        .ACT_LD   (ACT_LD),
        .PLL_LD   (PLL_LD)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .lp_req       (lp_req),
        .wake_req     (wake_req),
        .clk_off_mode (clk_off_mode),
        .clk_stable   (clk_stable),
        .tmr_expired  (tmr_expired),
        .state        (state),
        .mode_off     (mode_off),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val)
    );

    srseq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    srseq_drive u_drive (
        .state    (state),
        .mode_off (mode_off),
        .cmd      (cmd),
        .pins     (pins)
    );

    assign cke        = cmd.cke;
    assign cs_n       = cmd.cs_n;
    assign ras_n      = cmd.ras_n;
    assign cas_n      = cmd.cas_n;
    assign we_n       = cmd.we_n;
    assign reg_rst_n  = pins.reg_rst_n;
    assign bus_oe     = pins.bus_oe;
    assign clk_en     = pins.clk_en;
    assign exit_ready = pins.exit_ready;

    p_cke_low_in_reset_r4: assert property (@(posedge clk) disable iff (rst)
        !reg_rst_n |-> !cke);
    p_float_only_in_reset_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> !reg_rst_n);
    p_reset_after_pipe_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_rst_n) |-> ($past(cs_n) && !$past(cke) && !$past(cs_n, 2) && $past(we_n, 2)));
    p_rise_stable_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rst_n) |-> ($stable(cmd) && bus_oe && $past(bus_oe) && !cke));
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        exit_ready |=> (!exit_ready && cke));
    p_clk_off_in_lp_r5: assert property (@(posedge clk) disable iff (rst)
        !clk_en |-> (!bus_oe && !reg_rst_n));
endmodule

// File: tb/srseq_top_tb.sv
module srseq_top_tb;
    localparam int CLK_MHZ   = 200;
    localparam int PLL_US    = 1;
    localparam int ACT_CYC   = 6;
    localparam int INACT_CYC = 3;
    localparam int PLL_CYC   = PLL_US * CLK_MHZ;

    // observation order: cke cs_n ras_n cas_n we_n reg_rst_n bus_oe clk_en exit_ready
    localparam logic [8:0] O_NORMAL = 9'b1_1111_1110;
    localparam logic [8:0] O_SRE    = 9'b0_0001_1110;
    localparam logic [8:0] O_PIPE   = 9'b0_1111_1110;
    localparam logic [8:0] O_INACT  = 9'b0_1111_0110;
    localparam logic [8:0] O_LP_OFF = 9'b0_1111_0000;
    localparam logic [8:0] O_LP_ON  = 9'b0_1111_0010;
    localparam logic [8:0] O_CLKW   = 9'b0_1111_0010;
    localparam logic [8:0] O_PRE    = 9'b0_1111_0110;
    localparam logic [8:0] O_ACT    = 9'b0_1111_1110;
    localparam logic [8:0] O_READY  = 9'b0_1111_1111;

    // row: {clk_off, wake_during_entry, lp_in_lowpower, stable_lag[3:0]}
    localparam int NVEC = 6;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_0_0_0000,
        7'b1_0_0_0010,
        7'b0_1_0_0000,
        7'b1_1_0_0101,
        7'b0_0_1_0000,
        7'b1_0_1_0000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_req = 1'b0, wake_req = 1'b0, clk_off_mode = 1'b0, clk_stable = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, reg_rst_n, bus_oe, clk_en, exit_ready;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    srseq_top #(
        .CLK_MHZ(CLK_MHZ), .PLL_US(PLL_US), .ACT_CYC(ACT_CYC), .INACT_CYC(INACT_CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .lp_req(lp_req), .wake_req(wake_req),
        .clk_off_mode(clk_off_mode), .clk_stable(clk_stable),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .reg_rst_n(reg_rst_n), .bus_oe(bus_oe), .clk_en(clk_en), .exit_ready(exit_ready)
    );

    function automatic logic [8:0] obs();
        return {cke, cs_n, ras_n, cas_n, we_n, reg_rst_n, bus_oe, clk_en, exit_ready};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = obs();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // entry up to the first low-power cycle; optional wake pulse during the entry command
    task automatic do_entry(input logic off, input logic early);
        clk_off_mode = off;
        lp_req = 1'b1;
        tick();
        lp_req = 1'b0;
        clk_off_mode = ~off;           // mode must have been captured at entry (R5)
        chk("R2 entry command", O_SRE);
        wake_req = early;
        tick();
        wake_req = 1'b0;
        chk("R3 pipeline cycle", O_PIPE);
        for (int i = 0; i < INACT_CYC; i++) begin
            tick();
            chk("R4 deactivation wait", O_INACT);
        end
        tick();
        chk("R5 low power", off ? O_LP_OFF : O_LP_ON);
    endtask

    task automatic run_vec(input logic [6:0] v);
        logic off, early, extra;
        int lag;
        off = v[6]; early = v[5]; extra = v[4]; lag = int'(v[3:0]);
        chk("R1 idle before entry", O_NORMAL);
        do_entry(off, early);
        if (early) begin
            tick();                      // R10 pending wake acts on first low-power cycle
        end else begin
            if (extra) begin
                lp_req = 1'b1;
                tick();
                lp_req = 1'b0;
                chk("R11 lp_req in low power ignored", off ? O_LP_OFF : O_LP_ON);
            end
            tick();
            chk("R5 low power held", off ? O_LP_OFF : O_LP_ON);
            wake_req = 1'b1;
            tick();
            wake_req = 1'b0;
        end
        if (off) begin
            chk(early ? "R10 latched wake, clock request" : "R6 clock request", O_CLKW);
            for (int i = 0; i < lag; i++) begin
                tick();
                chk("R6 waiting for clk_stable", O_CLKW);
            end
            clk_stable = 1'b1;
            tick();
            for (int i = 0; i < PLL_CYC; i++) begin
                chk("R6 PLL settle", O_CLKW);
                tick();
            end
            clk_stable = 1'b0;
        end
        chk(early ? "R10 latched wake, pre-reset levels" : "R7 pre-reset levels", O_PRE);
        tick();
        for (int i = 0; i < ACT_CYC; i++) begin
            chk("R8 activation hold", O_ACT);
            tick();
        end
        chk("R9 exit ready", O_READY);
        tick();
        chk("R9 back to normal", O_NORMAL);
        tick();
    endtask

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        chk("R1 reset state", O_NORMAL);
        tick();

        for (int n = 0; n < NVEC; n++) begin
            run_vec(VEC[n]);
        end

        // R11: wake in normal operation is not remembered
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk("R11 wake in normal ignored", O_NORMAL);
        tick();
        do_entry(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11 stale wake did not exit", O_LP_ON);
        end
        // late wake on the last deactivation cycle path: wake directly from low power
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk("R7 wake from low power", O_PRE);

        // R1: synchronous reset in the middle of a sequence
        tick(); tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset mid-sequence", O_NORMAL);
        tick();
        chk("R1 stays normal after reset", O_NORMAL);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule